// File: doc/BRIEF.md
# Nine-Level Stacked-Carrier Gate Pattern Generator

This block drives the ten gate signals of a single-phase inverter built from two cascaded cells. Each cell is a full bridge fed from a split DC source, with a bidirectional switch tied to the source midpoint. A phase counter walks a sine magnitude table. The magnitude is scaled by an 8-bit modulation index and compared each clock against four identical triangular carriers, each stacked one quarter of full scale above the one below. The number of carriers the reference lies above is the level code, 0 to 4, for the current half cycle. A separate polarity bit, taken from the sign of the unrectified sine, selects which diagonal of each bridge conducts. Zero, four positive and four negative steps give nine output levels.

The controller sets `mod_idx` and raises `en`. The outputs are continuous switch commands, not a data stream, so no port has a valid/ready handshake: there is nothing to back-pressure. Every input is a plain control pin, and every output is refreshed on each clock while the block is enabled. The fundamental period is 2000 enabled clocks and the carrier period is 50 clocks, so 40 carrier periods fit in one fundamental period.

Top module: `mlpwm_gate_gen`

## Requirements
- R1: While `rst` is high or `en` is low at a rising edge, all outputs (`level`, `pol`, `pol_n`, `gates`) are 0 after that edge.
- R2: A phase counter ph (0..1999) and a carrier position c (0..49) are held at 0 while idle, and each advances by one per enabled edge, wrapping. c always equals ph mod 50. Outputs after an enabled edge reflect the ph value held before that edge, so the first enabled edge after idle shows ph = 0.
- R3: With p = ph mod 1000 and q = p when p ≤ 500, else 1000 − p, the magnitude is S(q) = floor(16·1000·q(1000−q) / (5·10^6 − 4·q(1000−q))), which gives 0..1000. The reference is S(q) × `mod_idx`, taking the value of `mod_idx` before the edge.
- R4: With t = c for c ≤ 25, else 50 − c, carrier k (k = 0..3) equals 63750·k + 2550·t.
- R5: `level` is the number of carriers that are strictly below the reference.
- R6: When enabled, `pol` = 1 for ph < 1000 and 0 otherwise, and `pol_n` is its complement.
- R7: For `mod_idx` ≤ 63, `level` never exceeds 1. With `mod_idx` = 64, level 2 is reached near the crest of each half cycle.
- R8: `gates` = {cell B, cell A}, 5 bits per cell: bit0 upper-left, bit1 lower-left, bit2 upper-right, bit3 lower-right, bit4 midpoint switch. Cell codes: zero = 01010; half = 11000 (pol=1) or 10010 (pol=0); full = 01001 (pol=1) or 00110 (pol=0). Cell A is zero at level 0, half at level 1 and full at levels 2 and up. Cell B is zero at levels up to 2, half at level 3 and full at level 4.
- R9: In either cell, the two switches of one leg are never on together, and the midpoint switch is never on together with an upper switch.
- R10: Across two consecutive enabled edges with an unchanged `mod_idx`, `level` changes by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds phases at zero and gates off |
| mod_idx | input | 8 | Modulation index, 255 = 1.0 |
| level | output | 3 | Level code 0..4 |
| pol | output | 1 | Positive half-cycle flag |
| pol_n | output | 1 | Complement of pol while enabled |
| gates | output | 10 | Gate commands for cell A (bits 4:0) and cell B (bits 9:5) |

## Verification
The hardest case to reach is the boundary between one and two active carriers. With `mod_idx` = 64, the second carrier is exceeded only in the few steps where the sine crest lines up with a carrier trough. With 63, it is never exceeded. Reaching these cases needs an unbroken enabled run from a phase restart with the index held constant. The stimulus therefore holds each directed index for whole fundamental periods after a disable/enable restart. Random segments then vary the index, enable and reset, so that restarts also occur mid-period.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

  localparam int unsigned CARRIERS   = 4;
  localparam int unsigned CELLS      = 2;
  localparam int unsigned CELL_GATES = 5;

  // gate bit positions inside one cell
  localparam int unsigned G_UL  = 0;
  localparam int unsigned G_LL  = 1;
  localparam int unsigned G_UR  = 2;
  localparam int unsigned G_LR  = 3;
  localparam int unsigned G_MID = 4;

  typedef enum logic [1:0] {CELL_ZERO, CELL_HALF, CELL_FULL} cell_state_e;

  // rational sine approximation over a half period of 'half' steps, scaled to 'amp'
  function automatic int unsigned sine_mag(int unsigned p, int unsigned half, int unsigned amp);
    longint unsigned prod, num, den;
    prod = 64'(p) * 64'(half - p);
    num  = 64'd16 * 64'(amp) * prod;
    den  = 64'd5 * 64'(half) * 64'(half) - 64'd4 * prod;
    return 32'(num / den);
  endfunction

  function automatic logic [CELL_GATES-1:0] cell_code(cell_state_e st, logic pos);
    logic [CELL_GATES-1:0] g;
    g = '0;
    unique case (st)
      CELL_ZERO: begin g[G_LL] = 1'b1; g[G_LR] = 1'b1; end
      CELL_HALF: begin g[G_MID] = 1'b1; if (pos) g[G_LR] = 1'b1; else g[G_LL] = 1'b1; end
      default:   begin
        if (pos) begin g[G_UL] = 1'b1; g[G_LR] = 1'b1; end
        else     begin g[G_UR] = 1'b1; g[G_LL] = 1'b1; end
      end
    endcase
    return g;
  endfunction

endpackage

// File: rtl/mlpwm_phase.sv
module mlpwm_phase #(
  parameter int unsigned FUND_STEPS = 2000,
  parameter int unsigned CAR_STEPS  = 50,
  parameter int unsigned PW = $clog2(FUND_STEPS),
  parameter int unsigned CW = $clog2(CAR_STEPS)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [PW-1:0] phase,
  output logic [CW-1:0] cpos
);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase <= '0;
      cpos  <= '0;
    end else begin
      phase <= (phase == PW'(FUND_STEPS - 1)) ? '0 : phase + 1'b1;
      cpos  <= (cpos == CW'(CAR_STEPS - 1)) ? '0 : cpos + 1'b1;
    end
  end

  AST_PHASE_LOCK: assert property (@(posedge clk) disable iff (rst)
    (32'(phase) % CAR_STEPS) == 32'(cpos)); // R2

endmodule

// File: rtl/mlpwm_ref.sv
module mlpwm_ref import mlpwm_pkg::*; #(
  parameter int unsigned FUND_STEPS = 2000,
  parameter int unsigned AMP        = 1000,
  parameter int unsigned MI_W       = 8,
  parameter int unsigned PW = $clog2(FUND_STEPS),
  parameter int unsigned RW = $clog2(AMP + 1) + MI_W
)(
  input  logic [PW-1:0]   phase,
  input  logic [MI_W-1:0] mod_idx,
  output logic [RW-1:0]   refmag,
  output logic            pos_half
);

  localparam int unsigned HALF = FUND_STEPS / 2;
  localparam int unsigned QTR  = HALF / 2;
  localparam int unsigned TW   = $clog2(AMP + 1);
  localparam int unsigned QW   = $clog2(QTR + 1);

  logic [TW-1:0] rom [QTR+1];
  logic [PW-1:0] hp, qi;

  // quarter-wave magnitude table, filled with constants at elaboration
  for (genvar i = 0; i <= QTR; i++) begin : g_rom
    assign rom[i] = TW'(sine_mag(i, HALF, AMP));
  end

  always_comb begin
    pos_half = phase < PW'(HALF);
    hp       = pos_half ? phase : phase - PW'(HALF);
    qi       = (hp > PW'(QTR)) ? PW'(HALF) - hp : hp;
    refmag   = RW'(rom[QW'(qi)]) * RW'(mod_idx);
  end

endmodule

// File: rtl/mlpwm_level.sv
module mlpwm_level import mlpwm_pkg::*; #(
  parameter int unsigned CAR_STEPS = 50,
  parameter int unsigned FULL      = 255000,
  parameter int unsigned CW = $clog2(CAR_STEPS),
  parameter int unsigned RW = 18,
  parameter int unsigned LW = $clog2(CARRIERS + 1)
)(
  input  logic [CW-1:0] cpos,
  input  logic [RW-1:0] refmag,
  output logic [LW-1:0] level
);

  localparam int unsigned TPEAK = CAR_STEPS / 2;
  localparam int unsigned QSPAN = FULL / CARRIERS;
  localparam int unsigned TSTEP = QSPAN / TPEAK;

  logic [RW-1:0]       slope, cofs;
  logic [CARRIERS-1:0] above;

  always_comb begin
    slope = (cpos <= CW'(TPEAK)) ? RW'(cpos) : RW'(CW'(CAR_STEPS) - cpos);
    cofs  = slope * RW'(TSTEP);
  end

  for (genvar k = 0; k < CARRIERS; k++) begin : g_car
    assign above[k] = refmag > (RW'(k * QSPAN) + cofs);
  end

  always_comb begin
    level = '0;
    for (int k = 0; k < CARRIERS; k++) level = level + LW'(above[k]);
  end

endmodule

// File: rtl/mlpwm_gates.sv
module mlpwm_gates import mlpwm_pkg::*; #(
  parameter int unsigned LW = $clog2(CARRIERS + 1)
)(
  input  logic [LW-1:0]               level,
  input  logic                        pos,
  output logic [CELLS*CELL_GATES-1:0] gates
);

  localparam int unsigned STEPS = CARRIERS / CELLS;

  for (genvar j = 0; j < CELLS; j++) begin : g_cell
    localparam int unsigned BASE = j * STEPS;
    cell_state_e st;
    always_comb begin
      if (level <= LW'(BASE))          st = CELL_ZERO;
      else if (level == LW'(BASE + 1)) st = CELL_HALF;
      else                             st = CELL_FULL;
    end
    assign gates[j*CELL_GATES +: CELL_GATES] = cell_code(st, pos);
  end

endmodule

// File: rtl/mlpwm_gate_gen.sv
module mlpwm_gate_gen import mlpwm_pkg::*; #(
  parameter int unsigned FUND_STEPS = 2000,
  parameter int unsigned CAR_STEPS  = 50,
  parameter int unsigned AMP        = 1000,
  parameter int unsigned MI_W       = 8,
  localparam int unsigned LW = $clog2(CARRIERS + 1),
  localparam int unsigned GW = CELLS * CELL_GATES
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [MI_W-1:0] mod_idx,
  output logic [LW-1:0]   level,
  output logic            pol,
  output logic            pol_n,
  output logic [GW-1:0]   gates
);

  localparam int unsigned PW   = $clog2(FUND_STEPS);
  localparam int unsigned CW   = $clog2(CAR_STEPS);
  localparam int unsigned RW   = $clog2(AMP + 1) + MI_W;
  localparam int unsigned FULL = AMP * ((1 << MI_W) - 1);
  localparam int unsigned MI_ONE_MAX = FULL / CARRIERS / AMP;

  logic [PW-1:0] phase;
  logic [CW-1:0] cpos;
  logic [RW-1:0] refmag;
  logic          pos_c;
  logic [LW-1:0] lvl_c;
  logic [GW-1:0] gate_c;

  mlpwm_phase #(.FUND_STEPS(FUND_STEPS), .CAR_STEPS(CAR_STEPS), .PW(PW), .CW(CW)) u_phase (
    .clk(clk), .rst(rst), .en(en), .phase(phase), .cpos(cpos));

  mlpwm_ref #(.FUND_STEPS(FUND_STEPS), .AMP(AMP), .MI_W(MI_W), .PW(PW), .RW(RW)) u_ref (
    .phase(phase), .mod_idx(mod_idx), .refmag(refmag), .pos_half(pos_c));

  mlpwm_level #(.CAR_STEPS(CAR_STEPS), .FULL(FULL), .CW(CW), .RW(RW), .LW(LW)) u_level (
    .cpos(cpos), .refmag(refmag), .level(lvl_c));

  mlpwm_gates #(.LW(LW)) u_gates (.level(lvl_c), .pos(pos_c), .gates(gate_c));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      level <= '0;
      pol   <= 1'b0;
      pol_n <= 1'b0;
      gates <= '0;
    end else begin
      level <= lvl_c;
      pol   <= pos_c;
      pol_n <= ~pos_c;
      gates <= gate_c;
    end
  end

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gates == '0) && (level == '0) && !pol && !pol_n); // R1

  AST_POL_COMPL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en)) |-> (pol != pol_n)); // R6

  AST_LOW_MI_ONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && ($past(mod_idx) <= MI_W'(MI_ONE_MAX))) |-> (level <= LW'(1))); // R7

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(en) && $past(en, 2) && ($past(mod_idx) == $past(mod_idx, 2)))
    |-> ((level <= $past(level) + LW'(1)) && ($past(level) <= level + LW'(1)))); // R10

  for (genvar j = 0; j < CELLS; j++) begin : g_chk
    localparam int unsigned B = j * CELL_GATES;
    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
      !(gates[B+G_UL] && gates[B+G_LL]) && !(gates[B+G_UR] && gates[B+G_LR]) &&
      !(gates[B+G_MID] && (gates[B+G_UL] || gates[B+G_UR]))); // R9
  end

endmodule

// File: tb/test_mlpwm_gate_gen.sv
module test_mlpwm_gate_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [7:0] mi  = 8'd0;
  logic [2:0] level;
  logic       pol, pol_n;
  logic [9:0] gates;

  int checks = 0, fails = 0;
  int mph = 0;
  int prev_level = -1, prev_mi = -1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mlpwm_gate_gen i_mlpwm_gate_gen (
    .clk(clk), .rst(rst), .en(en), .mod_idx(mi),
    .level(level), .pol(pol), .pol_n(pol_n), .gates(gates));

  function automatic int smag(int q);
    longint prod;
    prod = longint'(q) * longint'(1000 - q);
    return int'((64'd16000 * prod) / (64'd5000000 - 64'd4 * prod));
  endfunction

  function automatic int exp_level(int ph, int m);
    int p, q, r, c, t, lv;
    p = ph % 1000;
    q = (p > 500) ? 1000 - p : p;
    r = smag(q) * m;
    c = ph % 50;
    t = (c <= 25) ? c : 50 - c;
    lv = 0;
    for (int k = 0; k < 4; k++) if (r > 63750 * k + 2550 * t) lv++;
    return lv;
  endfunction

  function automatic logic [4:0] cell_code(int st, bit pos);
    if (st == 0) return 5'b01010;
    if (st == 1) return pos ? 5'b11000 : 5'b10010;
    return pos ? 5'b01001 : 5'b00110;
  endfunction

  function automatic logic [9:0] exp_gates(int lv, bit pos);
    int a, b;
    a = (lv == 0) ? 0 : (lv == 1) ? 1 : 2;
    b = (lv <= 2) ? 0 : (lv == 3) ? 1 : 2;
    return {cell_code(b, pos), cell_code(a, pos)};
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic cycle();
    bit idle;
    int el, m;
    bit ep;
    logic [9:0] eg;
    idle = rst || !en;
    m = int'(mi);
    el = 0; ep = 1'b0; eg = '0;
    if (idle) mph = 0;
    else begin
      el = exp_level(mph, m);
      ep = (mph < 1000);
      eg = exp_gates(el, ep);
      mph = (mph + 1) % 2000;
    end
    @(posedge clk);
    @(negedge clk);
    if (idle) begin
      check(level == 0 && !pol && !pol_n && gates == 0, "R1 idle outputs", int'(gates), 0);
      prev_level = -1;
    end else begin
      check(int'(level) == el, "R3,R4,R5 level", int'(level), el);
      check(pol == ep && pol_n == !ep, "R6 polarity", int'({pol, pol_n}), int'({ep, !ep}));
      check(gates == eg, "R8 gates", int'(gates), int'(eg));
      for (int j = 0; j < 2; j++) begin
        logic [4:0] g;
        g = gates[j*5 +: 5];
        check(!(g[0] && g[1]) && !(g[2] && g[3]) && !(g[4] && (g[0] || g[2])),
              "R9 shoot-through", int'(g), 0);
      end
      if (m <= 63) check(level <= 1, "R7 low index", int'(level), 1);
      if (prev_level >= 0 && prev_mi == m)
        check((int'(level) - prev_level <= 1) && (prev_level - int'(level) <= 1),
              "R10 single step", int'(level), prev_level);
      prev_level = int'(level);
      prev_mi = m;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int seen2, first, edges;
    void'($urandom(32'd4242));
    // R1: reset state
    run(3);
    rst = 1'b0;
    run(3);

    // R2: restart from phase zero; polarity falls after 1000 enabled steps
    mi = 8'd204; en = 1'b1;
    cycle();
    check(pol == 1'b1 && gates == 10'b0101001010, "R2 first step", int'(gates), 10'b0101001010);
    edges = 1;
    while (pol && edges < 1100) begin cycle(); edges++; end
    check(edges == 1001, "R2 half period", edges, 1001);
    run(1000);

    // full scale, one whole period
    mi = 8'd255; run(2000);
    // zero index keeps level at zero
    mi = 8'd0; run(200);

    // R7 boundary: 63 never reaches level 2, 64 does near the crest
    en = 1'b0; cycle(); mi = 8'd63; en = 1'b1;
    seen2 = 0;
    for (int i = 0; i < 2000; i++) begin cycle(); if (level >= 2) seen2++; end
    check(seen2 == 0, "R7 index 63", seen2, 0);
    en = 1'b0; cycle(); mi = 8'd64; en = 1'b1;
    seen2 = 0;
    for (int i = 0; i < 1000; i++) begin cycle(); if (level == 2) seen2++; end
    check(seen2 > 0, "R7 index 64", seen2, 1);

    // mid-period disable and restart
    mi = 8'd128; run(700);
    en = 1'b0; cycle(); cycle(); en = 1'b1;
    cycle();
    first = int'(pol);
    check(first == 1 && level == 0, "R2 restart", int'(level), 0);
    run(600);

    // random segments
    for (int s = 0; s < 50; s++) begin
      mi  = 8'($urandom_range(0, 255));
      en  = ($urandom_range(0, 7) != 0);
      rst = ($urandom_range(0, 19) == 0);
      run($urandom_range(20, 400));
      rst = 1'b0;
    end
    en = 1'b1; mi = 8'd230; run(2000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule